// File: doc/BRIEF.md
# Nonblocking Load Miss Buffer

This block sits behind the on-chip data cache and takes every load that missed it, so the pipeline can keep issuing work while those loads wait for a pipelined external cache. Entries are kept in arrival order in a nine-slot circular queue. Each slot holds the load's 16-byte subblock address, its destination register tag, its data and a flag that marks it as a subblock hit. The pipeline stalls only when the queue is full. Instructions that consume a load's value are interlocked elsewhere.

When a load enters, its subblock is compared with every entry already resident. If any of them covers the same 16 bytes, the new entry is marked as a hit and sends no external request. It takes its data from the 16-byte fill that the older entry brings in, which stands in for a read of the freshly refilled data cache line. Entries that are not hits send requests one per cycle, in order, tagged with their slot number. The external cache answers with the slot number and 16 bytes. Entries leave strictly in order through a completion port that carries the tag, the data and the hit flag.

Top module: `load_miss_buffer`

## Requirements
- R1: The queue holds up to DEPTH (default 9) loads, and `full` is high exactly while DEPTH entries are resident.
- R2: An enqueue presented while `full` is high is dropped. It never produces an external request or a completion.
- R3: Subblock matching compares address bits ADDR_W-1:4 and ignores bits 3:0. An entering load that matches any resident entry is marked as a hit, including an entry that is leaving in that same cycle.
- R4: A hit entry never issues an external request.
- R5: Non-hit entries issue external requests in enqueue order, at most one per cycle. Each request carries the slot number on `ecReqId` and the subblock address (address bits ADDR_W-1:4) on `ecReqAddr`.
- R6: Completions leave in enqueue order, one per cycle at most, each carrying the tag that was enqueued with it.
- R7: Every completion carries the 16-byte response data for its own subblock, whether the entry is a hit or a miss. A hit entry may get that data before, in the same cycle as, or after it enters.
- R8: `cmpHit` is 1 on a completion exactly when that entry was marked as a hit on entry.
- R9: After reset the queue is empty: `full`, `ecReqValid` and `cmpValid` are all low.
- R10: An entry that has already completed is no longer matched, so a later load to its subblock issues a new external request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enqValid | input | 1 | A missed load is presented |
| enqAddr | input | ADDR_W (40) | Physical byte address of the load |
| enqTag | input | TAG_W (5) | Destination register tag |
| full | output | 1 | All slots occupied; an enqueue is refused |
| ecReqValid | output | 1 | External cache request this cycle |
| ecReqId | output | SLOT_W (4) | Slot number of the requesting entry |
| ecReqAddr | output | ADDR_W-4 (36) | Subblock address requested |
| ecRspValid | input | 1 | External cache response this cycle |
| ecRspId | input | SLOT_W (4) | Slot number the response belongs to |
| ecRspData | input | DATA_W (128) | 16 bytes of returned data |
| cmpValid | output | 1 | A load completes this cycle |
| cmpTag | output | TAG_W (5) | Tag of the completing load |
| cmpData | output | DATA_W (128) | Data of the completing load |
| cmpHit | output | 1 | The completing load was a subblock hit |

## Verification
A wrong hit flag shows up quickly. A missing flag causes an unexpected external request one cycle after the load enters. A spurious flag means a request is missing, and the entry then stalls at the head, so completions stop until the drain timeout. Lost or misrouted fill data appears only when the affected entry reaches the head, which can be up to DEPTH completions later. It shows as wrong `cmpData` or a stuck queue. Pointer or count faults show as a completion tag out of order, `full` at the wrong occupancy, or a dropped or duplicated request in the ordered request stream.

// File: rtl/lmb_pkg.sv
package lmb_pkg;

  // Strobes from control to datapath for one cycle.
  typedef struct packed {
    logic enqWrite;     // store address and tag of the entering load
    logic enqCopySlot;  // entering hit copies data from a resident slot
    logic enqCopyRsp;   // entering hit copies data from this cycle's response
    logic rspWrite;     // write response data into the responding slot
  } lmb_strobe_t;

endpackage

// File: rtl/lmb_dpath.sv
module lmb_dpath
  import lmb_pkg::*;
#(
  parameter int DEPTH  = 9,
  parameter int ADDR_W = 40,
  parameter int SUB_LSB = 4,
  parameter int TAG_W  = 5,
  parameter int DATA_W = 128,
  localparam int SLOT_W = $clog2(DEPTH),
  localparam int SUB_W  = ADDR_W - SUB_LSB
) (
  input  logic              clk,
  input  lmb_strobe_t       strobe,
  input  logic [ADDR_W-1:0] enqAddr,
  input  logic [TAG_W-1:0]  enqTag,
  input  logic [SLOT_W-1:0] wrSlot,
  input  logic [SLOT_W-1:0] copySlot,
  input  logic [SLOT_W-1:0] issSlot,
  input  logic [SLOT_W-1:0] rdSlot,
  input  logic [SLOT_W-1:0] ecRspId,
  input  logic [DATA_W-1:0] ecRspData,
  input  logic [DEPTH-1:0]  fillMask,
  output logic [DEPTH-1:0]  matchVec,
  output logic [DEPTH-1:0]  rspMatchVec,
  output logic [SUB_W-1:0]  ecReqAddr,
  output logic [TAG_W-1:0]  cmpTag,
  output logic [DATA_W-1:0] cmpData
);

  logic [SUB_W-1:0]  subMem  [DEPTH];
  logic [TAG_W-1:0]  tagMem  [DEPTH];
  logic [DATA_W-1:0] dataMem [DEPTH];

  logic [SUB_W-1:0] enqSub;
  logic [SUB_W-1:0] rspSub;

  assign enqSub = enqAddr[ADDR_W-1:SUB_LSB];
  assign rspSub = subMem[ecRspId];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign matchVec[g]    = (subMem[g] == enqSub);
    assign rspMatchVec[g] = (subMem[g] == rspSub);
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (strobe.enqWrite && (wrSlot == SLOT_W'(g))) begin
        subMem[g] <= enqSub;
        tagMem[g] <= enqTag;
      end
      if (strobe.enqCopySlot && (wrSlot == SLOT_W'(g))) begin
        dataMem[g] <= dataMem[copySlot];
      end else if (strobe.enqCopyRsp && (wrSlot == SLOT_W'(g))) begin
        dataMem[g] <= ecRspData;
      end else if ((strobe.rspWrite && (ecRspId == SLOT_W'(g))) || fillMask[g]) begin
        dataMem[g] <= ecRspData;
      end
    end
  end

  assign ecReqAddr = subMem[issSlot];
  assign cmpTag    = tagMem[rdSlot];
  assign cmpData   = dataMem[rdSlot];

endmodule

// File: rtl/lmb_ctrl.sv
module lmb_ctrl
  import lmb_pkg::*;
#(
  parameter int DEPTH = 9,
  localparam int SLOT_W = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enqValid,
  input  logic [DEPTH-1:0]  matchVec,
  input  logic [DEPTH-1:0]  rspMatchVec,
  input  logic              ecRspValid,
  input  logic [SLOT_W-1:0] ecRspId,
  output logic              full,
  output logic [CNT_W-1:0]  occCount,
  output logic              ecReqValid,
  output logic [SLOT_W-1:0] issSlot,
  output logic [SLOT_W-1:0] rdSlot,
  output logic [SLOT_W-1:0] wrSlot,
  output logic [SLOT_W-1:0] copySlot,
  output logic [DEPTH-1:0]  fillMask,
  output logic              cmpValid,
  output logic              cmpHit,
  output lmb_strobe_t       strobe
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(DEPTH - 1);

  function automatic logic [SLOT_W-1:0] bump(input logic [SLOT_W-1:0] p);
    return (p == LAST_SLOT) ? '0 : p + 1'b1;
  endfunction

  logic [DEPTH-1:0] validQ, hitQ, readyQ;
  logic [SLOT_W-1:0] wrPtr, rdPtr, issPtr;
  logic [CNT_W-1:0]  count, scanCnt;

  logic enqAcc, enqHit, copyAvail, rspFeedsNew, scan, pop;
  logic [DEPTH-1:0] liveMatch, dataMatch;

  assign full      = (count == CNT_W'(DEPTH));
  assign occCount  = count;
  assign enqAcc    = enqValid && !full;
  assign liveMatch = matchVec & validQ;
  assign enqHit    = |liveMatch;
  assign dataMatch = liveMatch & readyQ;
  assign copyAvail = |dataMatch;
  assign rspFeedsNew = ecRspValid && liveMatch[ecRspId];

  always_comb begin
    copySlot = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (dataMatch[i]) copySlot = SLOT_W'(i);
    end
  end

  assign fillMask = ecRspValid ? (rspMatchVec & validQ & hitQ & ~readyQ) : '0;

  assign scan       = (scanCnt != '0);
  assign ecReqValid = scan && !hitQ[issPtr];
  assign pop        = validQ[rdPtr] && readyQ[rdPtr];
  assign cmpValid   = pop;
  assign cmpHit     = hitQ[rdPtr];

  assign issSlot = issPtr;
  assign rdSlot  = rdPtr;
  assign wrSlot  = wrPtr;

  always_comb begin
    strobe.enqWrite    = enqAcc;
    strobe.enqCopySlot = enqAcc && copyAvail;
    strobe.enqCopyRsp  = enqAcc && !copyAvail && rspFeedsNew;
    strobe.rspWrite    = ecRspValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ  <= '0;
      hitQ    <= '0;
      readyQ  <= '0;
      wrPtr   <= '0;
      rdPtr   <= '0;
      issPtr  <= '0;
      count   <= '0;
      scanCnt <= '0;
    end else begin
      if (ecRspValid) readyQ[ecRspId] <= 1'b1;
      readyQ <= (readyQ | fillMask) | (ecRspValid ? (DEPTH'(1) << ecRspId) : '0);
      if (pop) begin
        validQ[rdPtr] <= 1'b0;
        hitQ[rdPtr]   <= 1'b0;
        readyQ[rdPtr] <= 1'b0;
        rdPtr         <= bump(rdPtr);
      end
      if (enqAcc) begin
        validQ[wrPtr] <= 1'b1;
        hitQ[wrPtr]   <= enqHit;
        readyQ[wrPtr] <= copyAvail || rspFeedsNew;
        wrPtr         <= bump(wrPtr);
      end
      if (scan) issPtr <= bump(issPtr);
      count   <= count + CNT_W'(enqAcc) - CNT_W'(pop);
      scanCnt <= scanCnt + CNT_W'(enqAcc) - CNT_W'(scan);
    end
  end

endmodule

// File: rtl/load_miss_buffer.sv
module load_miss_buffer
  import lmb_pkg::*;
#(
  parameter int DEPTH   = 9,
  parameter int ADDR_W  = 40,
  parameter int SUB_LSB = 4,
  parameter int TAG_W   = 5,
  parameter int DATA_W  = 128,
  localparam int SLOT_W = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int SUB_W  = ADDR_W - SUB_LSB
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enqValid,
  input  logic [ADDR_W-1:0] enqAddr,
  input  logic [TAG_W-1:0]  enqTag,
  output logic              full,
  output logic              ecReqValid,
  output logic [SLOT_W-1:0] ecReqId,
  output logic [SUB_W-1:0]  ecReqAddr,
  input  logic              ecRspValid,
  input  logic [SLOT_W-1:0] ecRspId,
  input  logic [DATA_W-1:0] ecRspData,
  output logic              cmpValid,
  output logic [TAG_W-1:0]  cmpTag,
  output logic [DATA_W-1:0] cmpData,
  output logic              cmpHit
);

  lmb_strobe_t       strobe;
  logic [DEPTH-1:0]  matchVec, rspMatchVec, fillMask;
  logic [SLOT_W-1:0] issSlot, rdSlot, wrSlot, copySlot;
  logic [CNT_W-1:0]  occCount;

  lmb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .enqValid(enqValid),
    .matchVec(matchVec), .rspMatchVec(rspMatchVec),
    .ecRspValid(ecRspValid), .ecRspId(ecRspId),
    .full(full), .occCount(occCount), .ecReqValid(ecReqValid),
    .issSlot(issSlot), .rdSlot(rdSlot), .wrSlot(wrSlot),
    .copySlot(copySlot), .fillMask(fillMask),
    .cmpValid(cmpValid), .cmpHit(cmpHit), .strobe(strobe)
  );

  lmb_dpath #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .SUB_LSB(SUB_LSB),
    .TAG_W(TAG_W), .DATA_W(DATA_W)
  ) u_dpath (
    .clk(clk), .strobe(strobe), .enqAddr(enqAddr), .enqTag(enqTag),
    .wrSlot(wrSlot), .copySlot(copySlot), .issSlot(issSlot),
    .rdSlot(rdSlot), .ecRspId(ecRspId), .ecRspData(ecRspData),
    .fillMask(fillMask), .matchVec(matchVec), .rspMatchVec(rspMatchVec),
    .ecReqAddr(ecReqAddr), .cmpTag(cmpTag), .cmpData(cmpData)
  );

  assign ecReqId = issSlot;

endmodule

// File: rtl/lmb_chk.sv
module lmb_chk #(
  parameter int DEPTH = 9,
  localparam int SLOT_W = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              enqValid,
  input logic              full,
  input logic              ecReqValid,
  input logic [SLOT_W-1:0] ecReqId,
  input logic              cmpValid,
  input logic [CNT_W-1:0]  occCount
);

  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    occCount <= CNT_W'(DEPTH));

  a_r1_growth_needs_accept: assert property (@(posedge clk) disable iff (!rstN)
    (occCount > $past(occCount)) |-> ($past(enqValid) && !$past(full)));

  a_r2_reject_when_full: assert property (@(posedge clk) disable iff (!rstN)
    (full && enqValid) |=> (occCount <= $past(occCount)));

  a_r5_req_from_resident: assert property (@(posedge clk) disable iff (!rstN)
    ecReqValid |-> ((occCount != '0) && (ecReqId < SLOT_W'(DEPTH))));

  a_r6_cmp_from_resident: assert property (@(posedge clk) disable iff (!rstN)
    cmpValid |-> (occCount != '0));

endmodule

bind load_miss_buffer lmb_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rstN(rstN), .enqValid(enqValid), .full(full),
  .ecReqValid(ecReqValid), .ecReqId(ecReqId), .cmpValid(cmpValid),
  .occCount(occCount)
);

// File: tb/load_miss_buffer_tb_top.sv
module load_miss_buffer_tb_top;

  localparam int DEPTH  = 9;
  localparam int ADDR_W = 40;
  localparam int TAG_W  = 5;
  localparam int DATA_W = 128;
  localparam int SLOT_W = $clog2(DEPTH);
  localparam int SUB_W  = ADDR_W - 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enqValid = 1'b0;
  logic [ADDR_W-1:0] enqAddr = '0;
  logic [TAG_W-1:0]  enqTag = '0;
  logic full, ecReqValid, cmpValid, cmpHit;
  logic [SLOT_W-1:0] ecReqId;
  logic [SUB_W-1:0]  ecReqAddr;
  logic ecRspValid = 1'b0;
  logic [SLOT_W-1:0] ecRspId = '0;
  logic [DATA_W-1:0] ecRspData = '0;
  logic [TAG_W-1:0]  cmpTag;
  logic [DATA_W-1:0] cmpData;

  always #2.5 clk = ~clk;

  load_miss_buffer dut_i (
    .clk(clk), .rstN(rstN), .enqValid(enqValid), .enqAddr(enqAddr),
    .enqTag(enqTag), .full(full), .ecReqValid(ecReqValid),
    .ecReqId(ecReqId), .ecReqAddr(ecReqAddr), .ecRspValid(ecRspValid),
    .ecRspId(ecRspId), .ecRspData(ecRspData), .cmpValid(cmpValid),
    .cmpTag(cmpTag), .cmpData(cmpData), .cmpHit(cmpHit)
  );

  typedef struct { logic [TAG_W-1:0] tag; logic [SUB_W-1:0] sub; logic hit; } exp_t;
  typedef struct { logic [SLOT_W-1:0] id; logic [SUB_W-1:0] sub; int cyc; } ec_t;

  exp_t expQ[$];
  logic [SUB_W-1:0] reqQ[$];
  ec_t ecQ[$];

  int checks = 0, errors = 0, cyc = 0;
  int reqSeen = 0, cmpSeen = 0, hitSeen = 0;
  bit hold = 1'b0, monOn = 1'b0;

  function automatic logic [DATA_W-1:0] fillData(input logic [SUB_W-1:0] s);
    return {s[31:0] ^ 32'hA5A5_0000, s[35:4], ~s[31:0], s[31:0] * 32'd2654435761};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor and external cache model, all at the falling edge.
  always @(negedge clk) begin
    cyc++;
    if (monOn) begin
      if (enqValid && !full) begin
        exp_t e;
        e.tag = enqTag;
        e.sub = enqAddr[ADDR_W-1:4];
        e.hit = 1'b0;
        foreach (expQ[i]) if (expQ[i].sub == e.sub) e.hit = 1'b1;   // R3
        expQ.push_back(e);
        if (!e.hit) reqQ.push_back(e.sub);
      end
      if (cmpValid) begin
        cmpSeen++;
        if (cmpHit) hitSeen++;
        if (expQ.size() == 0) begin
          check(1'b0, "R6", "completion with empty reference", 128'(cmpTag), 0);
        end else begin
          exp_t f;
          f = expQ.pop_front();
          check(cmpTag == f.tag, "R6", "completion tag", 128'(cmpTag), 128'(f.tag));
          check(cmpData == fillData(f.sub), "R7", "completion data", cmpData, fillData(f.sub));
          check(cmpHit == f.hit, "R8", "hit flag", 128'(cmpHit), 128'(f.hit));
        end
      end
      if (ecReqValid) begin
        ec_t r;
        reqSeen++;
        if (reqQ.size() == 0) begin
          check(1'b0, "R4", "unexpected external request", 128'(ecReqAddr), 0);
        end else begin
          logic [SUB_W-1:0] s;
          s = reqQ.pop_front();
          check(ecReqAddr == s, "R5", "request subblock", 128'(ecReqAddr), 128'(s));
        end
        r.id = ecReqId; r.sub = ecReqAddr; r.cyc = cyc;
        ecQ.push_back(r);
      end
    end
    ecRspValid = 1'b0;
    if (!hold && ecQ.size() != 0 && (cyc - ecQ[0].cyc) >= 3) begin
      ec_t d;
      d = ecQ.pop_front();
      ecRspValid = 1'b1;
      ecRspId = d.id;
      ecRspData = fillData(d.sub);
    end
  end

  task automatic push(input logic [ADDR_W-1:0] a, input logic [TAG_W-1:0] t);
    @(posedge clk); #1;
    enqValid = 1'b1; enqAddr = a; enqTag = t;
  endtask

  task automatic idle();
    @(posedge clk); #1;
    enqValid = 1'b0;
  endtask

  task automatic drain(input string req);
    int n = 0;
    while ((expQ.size() != 0 || ecQ.size() != 0) && n < 2000) begin
      @(posedge clk); n++;
    end
    repeat (3) @(posedge clk);
    check(expQ.size() == 0, req, "queue drains", 128'(expQ.size()), 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(full == 1'b0, "R9", "full after reset", 128'(full), 0);
    check(ecReqValid == 1'b0, "R9", "request after reset", 128'(ecReqValid), 0);
    check(cmpValid == 1'b0, "R9", "completion after reset", 128'(cmpValid), 0);
  endtask

  task automatic t_single();
    int r0 = reqSeen;
    push(40'h12_3456_7890, 5'd1); idle();
    drain("R7");
    check(reqSeen - r0 == 1, "R5", "one request for one miss", 128'(reqSeen - r0), 1);
  endtask

  task automatic t_subblock();
    int r0 = reqSeen, h0 = hitSeen;
    push(40'h00_0000_1000, 5'd2);
    push(40'h00_0000_100F, 5'd3);  // same subblock, low bits differ
    push(40'h00_0000_1010, 5'd4);  // next subblock
    push(40'h00_0000_1008, 5'd5);
    idle();
    drain("R3");
    check(reqSeen - r0 == 2, "R4", "requests for two subblocks", 128'(reqSeen - r0), 2);
    check(hitSeen - h0 == 2, "R3", "hits in burst", 128'(hitSeen - h0), 2);
  endtask

  task automatic t_retired();
    int r0 = reqSeen;
    push(40'h00_00AB_C000, 5'd6); idle();
    drain("R10");
    push(40'h00_00AB_C004, 5'd7); idle();
    drain("R10");
    check(reqSeen - r0 == 2, "R10", "retired entry not matched", 128'(reqSeen - r0), 2);
  endtask

  task automatic t_full();
    int c0 = cmpSeen, r0 = reqSeen;
    hold = 1'b1;
    for (int i = 0; i < DEPTH; i++) push(40'h00_0100_0000 + 40'(i * 16), 5'(8 + i));
    @(negedge clk);
    check(full == 1'b0, "R1", "not full before last accept", 128'(full), 0);
    push(40'h00_0200_0000, 5'd31);     // presented while full, dropped
    @(negedge clk);
    check(full == 1'b1, "R1", "full at depth", 128'(full), 1);
    idle();
    repeat (4) @(posedge clk);
    hold = 1'b0;
    drain("R2");
    check(cmpSeen - c0 == DEPTH, "R2", "completions after reject", 128'(cmpSeen - c0), DEPTH);
    check(reqSeen - r0 == DEPTH, "R2", "requests after reject", 128'(reqSeen - r0), DEPTH);
    check(full == 1'b0, "R1", "full clears after drain", 128'(full), 0);
  endtask

  task automatic t_interleave();
    int h0 = hitSeen;
    push(40'h00_0300_0000, 5'd20);
    push(40'h00_0300_0040, 5'd21);
    push(40'h00_0300_0004, 5'd22);
    push(40'h00_0300_0044, 5'd23);
    idle();
    repeat (2) @(posedge clk);
    push(40'h00_0300_000C, 5'd24);   // may meet data already returned
    idle();
    drain("R6");
    check(hitSeen - h0 >= 2, "R8", "interleaved hits", 128'(hitSeen - h0), 2);
  endtask

  task automatic t_stream();
    for (int i = 0; i < 400; i++) begin
      @(posedge clk); #1;
      enqValid = ($urandom % 3) != 0;
      enqAddr = 40'h00_0400_0000 + 40'(($urandom % 6) * 16) + 40'($urandom % 16);
      enqTag = 5'($urandom);
      if (($urandom % 16) == 0) hold = ~hold;
    end
    idle();
    hold = 1'b0;
    drain("R7");
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired expected completion of all tests");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    monOn = 1'b1;
    t_reset();
    t_single();
    t_subblock();
    t_retired();
    t_full();
    t_interleave();
    t_stream();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule